// File: doc/BRIEF.md
# Carrier PWM Modulator

This block turns a duty-cycle word into a pulse train by comparing it against a digital counter carrier. The carrier runs as a sawtooth of `P` clock ticks or as a symmetric up/down triangle of `2P` ticks. Each shape also has an inverted form, which moves the on-interval to the other end of the carrier. A sync pulse re-anchors the carrier to an external time reference, shifted by a programmable phase. Duty, phase, period and shape requests on the input pins act as pending values. They reach the comparator only at defined carrier points, so a period in flight is never cut short or distorted by a software write.

The result leaves on one of two paths. The first is a single PWM line. The second is a complementary high-side/low-side pair, where a programmable dead-time keeps both sides low after every switching event. An activate input forces every output low without stopping the carrier.

Top module: `cbpwm_top`

## Requirements
- R1: While reset is held, and until the first pending duty is loaded, every output is low.
- R2: Shape code 2'b01 is a sawtooth. The index runs 0..P-1, the period is P ticks, and the output is high while the index is below the active duty. The pulse therefore opens the period and lasts duty ticks.
- R3: Shape code 2'b11 is an inverted sawtooth. The output is high for the last duty ticks of each period, so after a sync to index 0 the output rises P-duty+1 ticks later.
- R4: Shape code 2'b00 is a triangle with period 2P. It is high for 2*duty ticks centred on the carrier peak, and rises P-duty+1 ticks after a sync to index 0. Shape code 2'b10 is an inverted triangle, high for 2*duty ticks centred on the carrier minimum.
- R5: Pending duty and phase are loaded at the start of each period (index returns to 0). For sawtooth shapes this is the only load point, whatever the update-rate select says.
- R6: With a triangle shape and the update-rate select at 1, duty and phase are loaded again at the carrier peak (index = P), so the second half of a period can use a new duty.
- R7: Period, shape and update rate are loaded only at the start of a period, so a period change never shortens the period in progress. A period request below 2 counts as 2.
- R8: A sync pulse moves the carrier index to the active phase (in ticks of the full period). A phase equal to or above the period length counts as 0. A sync that lands on index 0 is also a load point.
- R9: Active duty 0 keeps the output low and active duty >= P keeps it high, with no pulse at any carrier point.
- R10: One clock after activate is sampled low, every output is low.
- R11: Output mode 0 drives the single line only (both pair outputs low). Mode 1 drives the pair only (the single line low).
- R12: In mode 1 the high side follows the comparator and the low side follows its complement. After every comparator edge both stay low for deadtime ticks, and they are never high together.
- R13: If the dead-time reaches or exceeds an on or off interval, the side belonging to that interval stays low for the whole interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| period_i | input | CW | Pending carrier period P in ticks |
| duty_i | input | CW | Pending duty in carrier levels |
| phase_i | input | CW | Pending phase offset in ticks of the full period |
| shape_i | input | 2 | Carrier shape code |
| dual_rate_i | input | 1 | 1 = extra load at the triangle peak |
| sync_i | input | 1 | Re-anchors the carrier to the phase offset |
| activate_i | input | 1 | 0 forces all outputs low |
| out_mode_i | input | 1 | 0 = single line, 1 = complementary pair |
| deadtime_i | input | DTW | Dead-time in ticks |
| pwm_o | output | 1 | Single PWM line |
| pwm_h_o | output | 1 | High-side output of the pair |
| pwm_l_o | output | 1 | Low-side output of the pair |

## Verification
Two pairs of events can fall in the same cycle. The first is a sync jump and a load point: a sync with phase 0 lands exactly on index 0. The benches restart every scenario this way and then judge the position of the first edge, which depends on the values loaded in that cycle. The second is a mid-period duty request and the comparison against the carrier peak. The duty is changed one tick after the restart, and the width of the pulse that straddles the peak must be 3+5 levels in double-rate mode but 3+3 in single-rate mode.

// File: rtl/cbpwm_pkg.sv
package cbpwm_pkg;

  typedef enum logic [1:0] {
    SHAPE_TRI  = 2'b00,
    SHAPE_SAW  = 2'b01,
    SHAPE_ITRI = 2'b10,
    SHAPE_ISAW = 2'b11
  } shape_e;

  // up/down carrier for code bit 0 clear
  function automatic logic is_tri(input shape_e s);
    logic [1:0] b;
    b = s;
    return ~b[0];
  endfunction

  // on-interval anchored at the top of the carrier levels
  function automatic logic on_at_top(input shape_e s);
    case (s)
      SHAPE_TRI:  return 1'b1;
      SHAPE_ISAW: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cbpwm_carrier.sv
module cbpwm_carrier
  import cbpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] phase_i,
  input  shape_e        shape_i,
  input  logic          dual_rate_i,
  input  logic          sync_i,
  output logic [CW:0]   idx_o,
  output logic [CW-1:0] period_a_o,
  output logic [CW-1:0] duty_a_o,
  output shape_e        shape_a_o,
  output logic          upd_start_o,
  output logic          upd_mid_o
);

  localparam int IW = CW + 1;
  localparam logic [CW-1:0] MIN_PERIOD = CW'(2);

  function automatic logic [CW-1:0] clamp_period(input logic [CW-1:0] p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  function automatic logic [IW-1:0] carrier_len(input logic [CW-1:0] p, input logic tri_c);
    return tri_c ? {p, 1'b0} : {1'b0, p};
  endfunction

  function automatic logic [IW-1:0] step_index(input logic [IW-1:0] i, input logic [IW-1:0] len);
    return (i >= len - IW'(1)) ? '0 : i + IW'(1);
  endfunction

  function automatic logic [IW-1:0] phase_target(input logic [CW-1:0] ph, input logic [IW-1:0] len);
    return ({1'b0, ph} >= len) ? '0 : {1'b0, ph};
  endfunction

  logic [IW-1:0] idx_q, idx_n, len;
  logic [CW-1:0] per_q, duty_q, ph_q;
  shape_e        shp_q;
  logic          dbl_q;
  logic          ld_start, ld_mid;

  always_comb begin
    len = carrier_len(per_q, is_tri(shp_q));
    if (sync_i) idx_n = phase_target(ph_q, len);
    else        idx_n = step_index(idx_q, len);
    ld_start = (idx_n == '0);
    ld_mid   = !ld_start && dbl_q && is_tri(shp_q) && (idx_n == {1'b0, per_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      per_q  <= MIN_PERIOD;
      duty_q <= '0;
      ph_q   <= '0;
      shp_q  <= SHAPE_SAW;
      dbl_q  <= 1'b0;
    end else begin
      idx_q <= idx_n;
      if (ld_start) begin
        per_q  <= clamp_period(period_i);
        shp_q  <= shape_i;
        dbl_q  <= dual_rate_i;
        duty_q <= duty_i;
        ph_q   <= phase_i;
      end else if (ld_mid) begin
        duty_q <= duty_i;
        ph_q   <= phase_i;
      end
    end
  end

  assign idx_o       = idx_q;
  assign period_a_o  = per_q;
  assign duty_a_o    = duty_q;
  assign shape_a_o   = shp_q;
  assign upd_start_o = ld_start;
  assign upd_mid_o   = ld_mid;

  // R7
  period_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> (idx_q == '0));

  // R6
  duty_at_load_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> ((idx_q == '0) ||
      (dbl_q && is_tri(shp_q) && idx_q == {1'b0, per_q})));

  // R4
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < carrier_len(per_q, is_tri(shp_q)));

endmodule

// File: rtl/cbpwm_compare.sv
module cbpwm_compare
  import cbpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW:0]   idx_i,
  input  logic [CW-1:0] period_a_i,
  input  logic [CW-1:0] duty_a_i,
  input  shape_e        shape_a_i,
  input  logic          activate_i,
  output logic          raw_o,
  output logic          en_o
);

  localparam int IW = CW + 1;
  localparam int SW = CW + 2;

  // carrier level: triangle folds the second half back down
  function automatic logic [IW-1:0] carrier_level(input logic [IW-1:0] i,
                                                  input logic [CW-1:0] p,
                                                  input logic tri_c);
    if (tri_c && i >= {1'b0, p}) return {p, 1'b0} - IW'(1) - i;
    return i;
  endfunction

  function automatic logic compare_on(input logic [IW-1:0] lvl,
                                      input logic [CW-1:0] p,
                                      input logic [CW-1:0] d,
                                      input shape_e s);
    logic [CW-1:0] dsat;
    logic          low_side, top_side;
    dsat     = (d > p) ? p : d;
    low_side = lvl < {1'b0, dsat};
    top_side = ({1'b0, lvl} + SW'(dsat)) >= SW'(p);
    return on_at_top(s) ? top_side : low_side;
  endfunction

  logic [IW-1:0] level;
  logic          on_c;
  logic          raw_q, en_q;

  always_comb begin
    level = carrier_level(idx_i, period_a_i, is_tri(shape_a_i));
    on_c  = compare_on(level, period_a_i, duty_a_i, shape_a_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      raw_q <= activate_i & on_c;
      en_q  <= activate_i;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;

  // R9
  duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_a_i == '0) |=> !raw_q);

  // R9
  duty_full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (activate_i && duty_a_i >= period_a_i) |=> raw_q);

endmodule

// File: rtl/cbpwm_deadtime.sv
module cbpwm_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw_i,
  input  logic           en_i,
  input  logic           dual_i,
  input  logic [DTW-1:0] deadtime_i,
  output logic           h_o,
  output logic           l_o
);

  localparam int NSIDE = 2;

  logic           lvl_q;
  logic [DTW-1:0] gap_q;
  logic [NSIDE-1:0] side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else if (!en_i) begin
      lvl_q <= 1'b0;
      gap_q <= deadtime_i;
    end else if (raw_i != lvl_q) begin
      lvl_q <= raw_i;
      gap_q <= deadtime_i;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - DTW'(1);
    end
  end

  // side 1 drives while the comparator is high, side 0 while low
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign side[s] = en_i && dual_i && (lvl_q == s[0]) && (gap_q == '0);
  end

  assign h_o = side[1];
  assign l_o = side[0];

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_o && l_o));

  // R12
  gap_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && raw_i != lvl_q && deadtime_i != '0) |=> (!h_o && !l_o));

endmodule

// File: rtl/cbpwm_top.sv
module cbpwm_top
  import cbpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  period_i,
  input  logic [CW-1:0]  duty_i,
  input  logic [CW-1:0]  phase_i,
  input  logic [1:0]     shape_i,
  input  logic           dual_rate_i,
  input  logic           sync_i,
  input  logic           activate_i,
  input  logic           out_mode_i,
  input  logic [DTW-1:0] deadtime_i,
  output logic           pwm_o,
  output logic           pwm_h_o,
  output logic           pwm_l_o
);

  localparam int IW = CW + 1;

  logic [IW-1:0] idx;
  logic [CW-1:0] period_a, duty_a;
  shape_e        shape_a;
  logic          upd_start, upd_mid;
  logic          raw, en;

  cbpwm_carrier #(.CW(CW)) u_carrier (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .phase_i     (phase_i),
    .shape_i     (shape_e'(shape_i)),
    .dual_rate_i (dual_rate_i),
    .sync_i      (sync_i),
    .idx_o       (idx),
    .period_a_o  (period_a),
    .duty_a_o    (duty_a),
    .shape_a_o   (shape_a),
    .upd_start_o (upd_start),
    .upd_mid_o   (upd_mid)
  );

  cbpwm_compare #(.CW(CW)) u_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_i      (idx),
    .period_a_i (period_a),
    .duty_a_i   (duty_a),
    .shape_a_i  (shape_a),
    .activate_i (activate_i),
    .raw_o      (raw),
    .en_o       (en)
  );

  cbpwm_deadtime #(.DTW(DTW)) u_deadtime (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (raw),
    .en_i       (en),
    .dual_i     (out_mode_i),
    .deadtime_i (deadtime_i),
    .h_o        (pwm_h_o),
    .l_o        (pwm_l_o)
  );

  assign pwm_o = raw & ~out_mode_i;

  // R10
  activate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !activate_i |=> (!pwm_o && !pwm_h_o && !pwm_l_o));

  // R5
  start_load_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_start |=> (idx == '0));

  // R6
  mid_load_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mid |=> (idx == {1'b0, period_a} && is_tri(shape_a)));

endmodule

// File: tb/sim_cbpwm_top.sv
module sim_cbpwm_top;

  localparam int CW  = 16;
  localparam int DTW = 8;
  localparam logic [1:0] TRI = 2'b00, SAW = 2'b01, ITRI = 2'b10, ISAW = 2'b11;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [CW-1:0]  period_i = CW'(20);
  logic [CW-1:0]  duty_i = '0;
  logic [CW-1:0]  phase_i = '0;
  logic [1:0]     shape_i = SAW;
  logic           dual_rate_i = 1'b0;
  logic           sync_i = 1'b0;
  logic           activate_i = 1'b1;
  logic           out_mode_i = 1'b0;
  logic [DTW-1:0] deadtime_i = '0;
  logic           pwm_o, pwm_h_o, pwm_l_o;

  int n_checks = 0;
  int n_fail   = 0;
  int overlap  = 0;

  always #10 clk = ~clk;

  cbpwm_top #(.CW(CW), .DTW(DTW)) u0 (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .phase_i(phase_i), .shape_i(shape_i), .dual_rate_i(dual_rate_i),
    .sync_i(sync_i), .activate_i(activate_i), .out_mode_i(out_mode_i),
    .deadtime_i(deadtime_i), .pwm_o(pwm_o), .pwm_h_o(pwm_h_o), .pwm_l_o(pwm_l_o)
  );

  always @(negedge clk) if (pwm_h_o && pwm_l_o) overlap++;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      1: return pwm_h_o;
      2: return pwm_l_o;
      default: return pwm_o;
    endcase
  endfunction

  task automatic sync_once();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] shp, input int p, input int d, input int ph,
                     input logic dbl, input logic mode, input int dt);
    @(negedge clk);
    shape_i = shp; period_i = CW'(p); duty_i = CW'(d); phase_i = CW'(ph);
    dual_rate_i = dbl; out_mode_i = mode; deadtime_i = DTW'(dt);
    sync_once();
    repeat (100) @(negedge clk);
    sync_once();
  endtask

  task automatic wait_rise(input int sel, output int j);
    logic prev;
    prev = sig(sel);
    j = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      j++;
      if (sig(sel) && !prev) return;
      prev = sig(sel);
    end
    j = -1;
  endtask

  task automatic pulse_width(input int sel, output int w);
    w = 1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!sig(sel)) return;
      w++;
    end
  endtask

  task automatic count_high(input int sel, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sig(sel)) c++;
    end
  endtask

  task automatic t_reset();
    int c;
    check("R1 pwm in reset", int'(pwm_o), 0);
    check("R1 pair in reset", int'(pwm_h_o | pwm_l_o), 0);
    @(negedge clk); rst_n = 1'b1;
    count_high(0, 10, c);
    check("R1 pwm after reset", c, 0);
  endtask

  task automatic t_sawtooth();
    int c, j, w;
    cfg(SAW, 20, 5, 0, 1'b1, 1'b0, 0);
    duty_i = CW'(8);
    count_high(0, 19, c);
    check("R5 sawtooth keeps duty mid-period despite rate select", c, 5);
    wait_rise(0, j);
    check("R2 sawtooth pulse opens period", j, 2);
    pulse_width(0, w);
    check("R2 sawtooth width", w, 8);
    wait_rise(0, j);
    check("R2 sawtooth period", j, 20 - 8);
  endtask

  task automatic t_inv_saw();
    int j, w;
    cfg(ISAW, 20, 5, 0, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    check("R3 inverted sawtooth rise position", j, 16);
    pulse_width(0, w);
    check("R3 inverted sawtooth width", w, 5);
    cfg(ISAW, 20, 5, 4, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    check("R8 phase 4 advances rise", j, 12);
  endtask

  task automatic t_triangle();
    int j, w;
    cfg(TRI, 10, 3, 0, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    check("R4 triangle rise at peak side", j, 8);
    pulse_width(0, w);
    check("R4 triangle width", w, 6);
    wait_rise(0, j);
    check("R4 triangle period", j, 20 - 6);
    cfg(TRI, 10, 3, 20, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    check("R8 phase equal to length acts as 0", j, 8);
    cfg(ITRI, 10, 3, 0, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    pulse_width(0, w);
    wait_rise(0, j);
    pulse_width(0, w);
    check("R4 inverted triangle width", w, 6);
    wait_rise(0, j);
    check("R4 inverted triangle period", j, 20 - 6);
  endtask

  task automatic t_update_rate();
    int j, w;
    cfg(TRI, 10, 3, 0, 1'b1, 1'b0, 0);
    duty_i = CW'(5);
    wait_rise(0, j);
    check("R6 double-rate first half unchanged", j, 8);
    pulse_width(0, w);
    check("R6 double-rate peak load widens second half", w, 8);
    wait_rise(0, j);
    pulse_width(0, w);
    check("R6 double-rate next period", w, 10);
    cfg(TRI, 10, 3, 0, 1'b0, 1'b0, 0);
    duty_i = CW'(5);
    wait_rise(0, j);
    pulse_width(0, w);
    check("R5 single-rate keeps duty through peak", w, 6);
    wait_rise(0, j);
    pulse_width(0, w);
    check("R5 single-rate loads at period end", w, 10);
  endtask

  task automatic t_period_change();
    int j, w;
    cfg(ISAW, 20, 5, 0, 1'b0, 1'b0, 0);
    period_i = CW'(12);
    wait_rise(0, j);
    check("R7 running period not truncated", j, 16);
    pulse_width(0, w);
    wait_rise(0, j);
    check("R7 new period from next start", j, 12 - 5);
    cfg(SAW, 1, 1, 0, 1'b0, 1'b0, 0);
    wait_rise(0, j);
    pulse_width(0, w);
    check("R7 period below 2 counts as 2", w, 1);
  endtask

  task automatic t_duty_limits();
    int c;
    cfg(SAW, 20, 0, 0, 1'b0, 1'b0, 0);
    count_high(0, 60, c);
    check("R9 duty 0 constant low", c, 0);
    cfg(SAW, 20, 20, 0, 1'b0, 1'b0, 0);
    count_high(0, 60, c);
    check("R9 duty equal period constant high", c, 60);
    cfg(TRI, 10, 25, 0, 1'b0, 1'b0, 0);
    count_high(0, 60, c);
    check("R9 duty above period constant high", c, 60);
  endtask

  task automatic t_activate();
    int c;
    cfg(SAW, 20, 20, 0, 1'b0, 1'b0, 0);
    check("R10 active output high", int'(pwm_o), 1);
    activate_i = 1'b0;
    @(negedge clk);
    check("R10 single line off one tick later", int'(pwm_o), 0);
    count_high(0, 30, c);
    check("R10 stays off", c, 0);
    out_mode_i = 1'b1; activate_i = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 pair high side on at full duty", int'(pwm_h_o), 1);
    activate_i = 1'b0;
    @(negedge clk);
    check("R10 pair off one tick later", int'(pwm_h_o | pwm_l_o), 0);
    activate_i = 1'b1;
  endtask

  task automatic t_deadtime();
    int j, w, c;
    cfg(SAW, 20, 8, 0, 1'b0, 1'b1, 3);
    overlap = 0;
    wait_rise(1, j);
    pulse_width(1, w);
    wait_rise(1, j);
    pulse_width(1, w);
    check("R12 high side shortened by dead-time", w, 8 - 3);
    wait_rise(2, j);
    pulse_width(2, w);
    check("R12 low side shortened by dead-time", w, 12 - 3);
    count_high(0, 40, c);
    check("R11 single line idle in pair mode", c, 0);
    check("R12 sides never high together", overlap, 0);
    cfg(SAW, 20, 2, 0, 1'b0, 1'b1, 4);
    repeat (40) @(negedge clk);
    count_high(1, 60, c);
    check("R13 short on-interval suppresses high side", c, 0);
    wait_rise(2, j);
    pulse_width(2, w);
    check("R13 low side width", w, 18 - 4);
    cfg(SAW, 20, 8, 0, 1'b0, 1'b0, 3);
    count_high(1, 40, c);
    check("R11 pair idle in single mode", c, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sawtooth();
    t_inv_saw();
    t_triangle();
    t_update_rate();
    t_period_change();
    t_duty_limits();
    t_activate();
    t_deadtime();
    finish_run();
  end

endmodule